// File: doc/BRIEF.md
# Unaligned Vector Lane Aligner

This block steers bytes between a 16-byte aligned memory line and a 16-byte vector register so that a vector access at any byte address can be split into a "left" part and a "right" part. The low four bits of the effective address (the offset) choose complementary byte windows. The left part covers the bytes from the address up to the end of its 16-byte block. The right part covers the bytes of the block that come before the address, and it is empty when the address is aligned.

There are four operations. For the two loads, the block takes the aligned memory line and returns a register value whose unused lanes are zero. For the two stores, it takes a register value and returns a block-aligned write-data line with one byte-enable per block byte. A full unaligned load is formed outside the block by ORing a left load at address A with a right load at A+16. A full unaligned store is formed in the same way, from a left store at A followed by a right store at A+16.

The result is registered. It appears one clock after a request is presented, and it holds until the next request.

Top module: `vec_lane_aligner`

## Requirements
- R1: While reset is asserted and after it is released with no request, `rsp_valid`, `ld_data`, `st_data` and `st_be` are all zero.
- R2: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high.
- R3: Load-left (op code 0) with offset s puts line bytes s..15 into register lanes 0..15-s and zeroes lanes 16-s..15.
- R4: Load-right (op code 1) with a nonzero offset s puts line bytes 0..s-1 into register lanes 16-s..15 and zeroes lanes 0..15-s.
- R5: Load-right with offset 0 returns an all-zero register value.
- R6: Store-left (op code 2) with offset s writes register lanes 0..15-s to block bytes s..15. `st_be[k]` is 1 exactly for k >= s.
- R7: Store-right (op code 3) with offset s writes register lanes 16-s..15 to block bytes 0..s-1. `st_be[k]` is 1 exactly for k < s, so it is all zero when s is 0.
- R8: A load drives `st_data` and `st_be` to zero. A store drives `ld_data` to zero. Store-data bytes whose enable is low are zero.
- R9: Lane and block byte 0 occupy bits 127:120 and byte k occupies bits 127-8k down to 120-8k. `st_be[k]` belongs to block byte k.
- R10: The OR of a load-left at address A and a load-right at A+16, each given its own block's line, equals the 16 memory bytes starting at A.
- R11: In a cycle with `req_valid` low, `ld_data`, `st_data` and `st_be` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 load-left, 1 load-right, 2 store-left, 3 store-right |
| req_offset | input | 4 | Low four bits of the effective address |
| mem_line | input | 128 | Aligned memory line of the address's block (used by loads) |
| src_vec | input | 128 | Register value to be stored (used by stores) |
| rsp_valid | output | 1 | Result registers updated last cycle |
| ld_data | output | 128 | Register value for loads, zero-filled lanes |
| st_data | output | 128 | Block-aligned write data for stores |
| st_be | output | 16 | Byte enables for stores, bit k for block byte k |

## Verification
Each result lands in the output registers on the first rising edge after the request is presented, so `ld_data`, `st_data`, `st_be` and `rsp_valid` are due exactly one cycle after the stimulus. The bench drives a request on a falling edge and samples on the next falling edge, halfway past the single register stage. There, for every op and offset in its table, it compares the outputs with a byte-loop model written from the window rules above. It then idles for two falling edges to confirm that the data hold and that `rsp_valid` drops. The left/right combination is checked by capturing two consecutive one-cycle results and ORing them in the bench.

// File: rtl/vla_pkg.sv
package vla_pkg;
  typedef enum logic [1:0] {
    OP_LD_LEFT  = 2'd0,
    OP_LD_RIGHT = 2'd1,
    OP_ST_LEFT  = 2'd2,
    OP_ST_RIGHT = 2'd3
  } vla_op_e;

  function automatic logic op_is_store(input vla_op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_right(input vla_op_e op);
    return op[0];
  endfunction
endpackage

// File: rtl/vla_window.sv
module vla_window #(
  parameter int BYTES = 16,
  localparam int OFS_W = $clog2(BYTES)
) (
  input  logic [OFS_W-1:0] offset,
  input  logic             is_store,
  input  logic             is_right,
  output logic [BYTES-1:0] mask
);
  localparam logic [OFS_W:0] FULL = (OFS_W+1)'(BYTES);

  logic [OFS_W:0] bound;
  logic           upper_sel;

  // Loads count lanes from the register side, stores from the block side.
  always_comb begin
    bound     = is_store ? {1'b0, offset} : (FULL - {1'b0, offset});
    upper_sel = is_store ^ is_right;
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    localparam logic [OFS_W:0] IDX = (OFS_W+1)'(i);
    always_comb begin
      mask[i] = upper_sel ? (IDX >= bound) : (IDX < bound);
    end
  end

  // The number of lanes selected follows from the offset alone.
  always_comb begin
    if (!is_right) begin
      p_left_count_r3: assert ($countones(mask) == (BYTES - int'(offset)))
        else $error("left window size wrong");
    end else begin
      p_right_count_r4: assert ($countones(mask) == int'(offset))
        else $error("right window size wrong");
    end
    if (is_right && offset == '0) begin
      p_right_empty_r5: assert (mask == '0)
        else $error("right window not empty at aligned offset");
    end
  end
endmodule

// File: rtl/vla_rotator.sv
module vla_rotator #(
  parameter int BYTES  = 16,
  parameter int LANE_W = 8,
  localparam int OFS_W = $clog2(BYTES),
  localparam int VEC_W = BYTES * LANE_W
) (
  input  logic [VEC_W-1:0] din,
  input  logic [OFS_W-1:0] amount,
  input  logic             reverse,
  output logic [VEC_W-1:0] dout
);
  // Output lane i takes input lane (i + rot) mod BYTES, lane 0 at the MSB end.
  logic [OFS_W-1:0] rot;
  logic [VEC_W-1:0] stg [OFS_W+1];

  always_comb begin
    rot    = reverse ? (OFS_W'(0) - amount) : amount;
    stg[0] = din;
  end

  for (genvar s = 0; s < OFS_W; s++) begin : g_stage
    localparam int SH = (1 << s) * LANE_W;
    always_comb begin
      stg[s+1] = rot[s] ? {stg[s][VEC_W-1-SH:0], stg[s][VEC_W-1 -: SH]}
                        : stg[s];
    end
  end

  assign dout = stg[OFS_W];
endmodule

// File: rtl/vec_lane_aligner.sv
module vec_lane_aligner #(
  parameter int BYTES  = 16,
  parameter int LANE_W = 8,
  localparam int OFS_W = $clog2(BYTES),
  localparam int VEC_W = BYTES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [VEC_W-1:0] mem_line,
  input  logic [VEC_W-1:0] src_vec,
  output logic             rsp_valid,
  output logic [VEC_W-1:0] ld_data,
  output logic [VEC_W-1:0] st_data,
  output logic [BYTES-1:0] st_be
);
  import vla_pkg::*;

  vla_op_e          op;
  logic             is_store;
  logic             is_right;
  logic [VEC_W-1:0] rot_in;
  logic [VEC_W-1:0] rot_out;
  logic [BYTES-1:0] win;
  logic [VEC_W-1:0] masked;

  logic [VEC_W-1:0] ld_nxt, st_nxt;
  logic [BYTES-1:0] be_nxt;
  logic             past_ok;

  always_comb begin
    op       = vla_op_e'(req_op);
    is_store = op_is_store(op);
    is_right = op_is_right(op);
    rot_in   = is_store ? src_vec : mem_line;
  end

  vla_rotator #(.BYTES(BYTES), .LANE_W(LANE_W)) u_rot (
    .din     (rot_in),
    .amount  (req_offset),
    .reverse (is_store),
    .dout    (rot_out)
  );

  vla_window #(.BYTES(BYTES)) u_win (
    .offset   (req_offset),
    .is_store (is_store),
    .is_right (is_right),
    .mask     (win)
  );

  for (genvar i = 0; i < BYTES; i++) begin : g_mask
    always_comb begin
      masked[VEC_W-1-i*LANE_W -: LANE_W] =
        win[i] ? rot_out[VEC_W-1-i*LANE_W -: LANE_W] : '0;
    end
  end

  // Next-state
  always_comb begin
    ld_nxt = is_store ? '0 : masked;
    st_nxt = is_store ? masked : '0;
    be_nxt = is_store ? win : '0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      past_ok   <= 1'b0;
      ld_data   <= '0;
      st_data   <= '0;
      st_be     <= '0;
    end else begin
      rsp_valid <= req_valid;
      past_ok   <= 1'b1;
      if (req_valid) begin
        ld_data <= ld_nxt;
        st_data <= st_nxt;
        st_be   <= be_nxt;
      end
    end
  end

  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (rsp_valid == $past(req_valid)))
    else $error("response valid not one cycle after request");

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(req_valid)) |->
      ($stable(ld_data) && $stable(st_data) && $stable(st_be)))
    else $error("outputs changed without a request");

  p_load_quiet_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(req_valid) && !$past(req_op[1])) |->
      (st_be == '0 && st_data == '0))
    else $error("load drove store outputs");

  p_store_quiet_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(req_valid) && $past(req_op[1])) |-> (ld_data == '0))
    else $error("store drove load data");
endmodule

// File: tb/tb_vec_lane_aligner.sv
module tb_vec_lane_aligner;
  localparam int NV = 12;
  // {op[1:0], offset[3:0], expected byte enables[15:0]}
  localparam logic [21:0] TAB [NV] = '{
    {2'd0, 4'd0,  16'h0000},
    {2'd0, 4'd5,  16'h0000},
    {2'd0, 4'd15, 16'h0000},
    {2'd1, 4'd0,  16'h0000},
    {2'd1, 4'd1,  16'h0000},
    {2'd1, 4'd9,  16'h0000},
    {2'd2, 4'd0,  16'hFFFF},
    {2'd2, 4'd3,  16'hFFF8},
    {2'd2, 4'd15, 16'h8000},
    {2'd3, 4'd0,  16'h0000},
    {2'd3, 4'd6,  16'h003F},
    {2'd3, 4'd15, 16'h7FFF}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic [1:0]   req_op;
  logic [3:0]   req_offset;
  logic [127:0] mem_line, src_vec;
  logic         rsp_valid;
  logic [127:0] ld_data, st_data;
  logic [15:0]  st_be;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vec_lane_aligner dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_offset(req_offset), .mem_line(mem_line), .src_vec(src_vec),
    .rsp_valid(rsp_valid), .ld_data(ld_data), .st_data(st_data), .st_be(st_be)
  );

  function automatic logic [7:0] mbyte(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  function automatic logic [127:0] block_line(input int base);
    logic [127:0] l;
    for (int k = 0; k < 16; k++) l[8*(15-k) +: 8] = mbyte(base + k);
    return l;
  endfunction

  function automatic logic [7:0] gb(input logic [127:0] v, input int k);
    return v[8*(15-k) +: 8];
  endfunction

  // Byte-loop model of the four windows.
  function automatic logic [127:0] ref_out(input logic [1:0] op, input int s,
                                           input logic [127:0] mem,
                                           input logic [127:0] rv);
    logic [127:0] o = '0;
    for (int i = 0; i < 16; i++) begin
      case (op)
        2'd0: if (i < 16 - s) o[8*(15-i) +: 8] = gb(mem, s + i);
        2'd1: if (s != 0 && i >= 16 - s) o[8*(15-i) +: 8] = gb(mem, i - (16 - s));
        2'd2: if (i >= s) o[8*(15-i) +: 8] = gb(rv, i - s);
        default: if (i < s) o[8*(15-i) +: 8] = gb(rv, 16 - s + i);
      endcase
    end
    return o;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [3:0] ofs,
                       input logic [127:0] ml, input logic [127:0] sv);
    @(negedge clk);
    req_valid  = 1'b1;
    req_op     = op;
    req_offset = ofs;
    mem_line   = ml;
    src_vec    = sv;
    @(negedge clk);
    req_valid  = 1'b0;
  endtask

  initial begin
    logic [127:0] mline, rvec, l_part, r_part, want;
    mline = block_line(64);
    for (int k = 0; k < 16; k++) rvec[8*(15-k) +: 8] = 8'(8'h30 + k);

    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_offset = '0;
    mem_line = '0; src_vec = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 outputs in reset", {ld_data ^ st_data, 112'h0, st_be},
        {128'h0});
    chk("R1 valid in reset", {127'h0, rsp_valid}, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {127'h0, rsp_valid} | ld_data | st_data | {112'h0, st_be}, 128'h0);

    for (int t = 0; t < NV; t++) begin
      logic [1:0]  op;
      logic [3:0]  s;
      logic [15:0] ebe;
      string       tg;
      {op, s, ebe} = TAB[t];
      issue(op, s, mline, rvec);
      want = ref_out(op, int'(s), mline, rvec);
      case (op)
        2'd0: tg = "R3 load-left";
        2'd1: tg = (s == 0) ? "R5 load-right aligned" : "R4 load-right";
        2'd2: tg = "R6 store-left";
        default: tg = "R7 store-right";
      endcase
      chk("R2 valid one cycle after request", {127'h0, rsp_valid}, 128'h1);
      if (op[1]) begin
        chk(tg, st_data, want);
        chk({tg, " enables"}, {112'h0, st_be}, {112'h0, ebe});
        chk("R8 store leaves load data zero", ld_data, 128'h0);
      end else begin
        chk(tg, ld_data, want);
        chk("R8 load leaves store outputs zero", st_data | {112'h0, st_be}, 128'h0);
      end
    end

    // R11 / R2: idle with different inputs, outputs must hold.
    want = st_data;
    req_op = 2'd0; req_offset = 4'd7; mem_line = ~mline; src_vec = ~rvec;
    @(negedge clk);
    @(negedge clk);
    chk("R11 store data held", st_data, want);
    chk("R11 enables held", {112'h0, st_be}, {112'h0, 16'h7FFF});
    chk("R11 load data held", ld_data, 128'h0);
    chk("R2 valid low when idle", {127'h0, rsp_valid}, 128'h0);

    // R10 / R9: address 0x13 left, 0x23 right.
    issue(2'd0, 4'h3, block_line(16), rvec);
    l_part = ld_data;
    issue(2'd1, 4'h3, block_line(32), rvec);
    r_part = ld_data;
    for (int i = 0; i < 16; i++) want[8*(15-i) +: 8] = mbyte(19 + i);
    chk("R10 left OR right", l_part | r_part, want);
    chk("R9 lane 0 is the top byte", {120'h0, l_part[127:120]},
        {120'h0, mbyte(19)});
    chk("R9 last lane is the low byte", {120'h0, r_part[7:0]},
        {120'h0, mbyte(34)});

    // R5 with a nonzero line and register, aligned store-right has no enables.
    issue(2'd1, 4'h0, {16{8'hFF}}, rvec);
    chk("R5 aligned load-right zero", ld_data, 128'h0);
    issue(2'd3, 4'h0, mline, {16{8'hFF}});
    chk("R7 aligned store-right no enables", {112'h0, st_be} | st_data, 128'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule